// File: doc/BRIEF.md
# Character LCD Host Bus Sequencer

This block is the host-side engine for a character LCD controller with a parallel bus. Upstream logic hands it one byte at a time over a valid/ready handshake. Each byte carries a flag that marks it as a command or as display data. The block drives the enable strobe and the register-select line, and keeps the read/write line low at all times. Its bus width is fixed when it is built. In the 4-bit build, each byte goes out on the upper four data lines as two strobes. In the 8-bit build, each byte goes out as one strobe.

After reset the block runs the start-up sequence without any help from the host. First it waits out a power-up delay. It then sends three single-strobe 0011 nibbles, which force the display into a known bus width. The 4-bit build next sends a single-strobe 0010 nibble. Last comes a complete function-set byte built from a flag parameter. Every timing value is a parameter counted in system clock cycles: the power-up delay, data setup before the strobe, strobe high time, strobe low time, the normal instruction wait and the long wait. The normal wait should be sized for the slowest display oscillator, about 53 µs. The long wait covers clear and return-home, which are commands 0x01, 0x02 and 0x03.

The handshake is open only when the block is idle. It is closed through start-up, through every transfer and through the wait that follows each transfer. The host therefore cannot split a nibble pair or shorten a wait.

Top module: `lcd_bus_seq`

## Requirements
- R1: After reset, the enable strobe stays low and `req_ready` stays low for at least `T_POWERUP` cycles.
- R2: The first three strobes after reset carry 0011 on D7–D4 with RS low, each as a single strobe, and are spaced by at least `T_LONG` cycles.
- R3: The 4-bit build then sends 0010 on D7–D4 as a single strobe, followed by the byte {0010, `FSET_FLAGS`} as a nibble pair. The 8-bit build instead sends {0011, `FSET_FLAGS`} as one strobe. All start-up strobes have RS low.
- R4: `req_ready` is high only when start-up has finished, no strobe is high, no nibble pair is half sent and the wait after the last byte has expired.
- R5: In the 8-bit build, each accepted byte appears on D7–D0 during one strobe, with RS equal to the byte's data flag (1 = data, 0 = command).
- R6: In the 4-bit build, each accepted byte appears as two strobes, bits 7–4 first and then bits 3–0, on D7–D4. D3–D0 are driven to 0 and RS is the same for both strobes.
- R7: RS and D7–D0 do not change while the strobe is high, and are valid for at least `T_SETUP` cycles before it rises.
- R8: Every strobe is high for exactly `T_EHIGH` cycles.
- R9: The time from a byte's last strobe fall to the next byte's first strobe rise is at least `T_CMD` cycles. After command 0x01, 0x02 or 0x03 it is at least `T_LONG` cycles.
- R10: The read/write line is always low.
- R11: A request offered while `req_ready` is low and withdrawn before `req_ready` rises is never sent to the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a byte |
| req_ready | output | 1 | Block accepts the offered byte on this edge |
| req_is_data | input | 1 | 1 = display data (RS high), 0 = command |
| req_byte | input | 8 | Byte to transfer |
| lcd_e | output | 1 | Enable strobe; the display latches on its falling edge |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read/write, held low |
| lcd_d | output | 8 | Data bus; in the 4-bit build only D7–D4 carry data |

## Verification
If the nibble-phase bit is wrong, the display shifts by half a byte on the very next strobe. A monitor that rebuilds bytes from strobe falls therefore reports it at once, and every byte after it also mismatches. If the start-up step counter is wrong, the block opens `req_ready` too early or sends the wrong start-up nibble, which shows within the first few strobes. A wait counter that is loaded with the wrong value shows as a strobe gap that is too short, measured at the next rising edge of the strobe. A wrong long-command decode shows in the same way, as a short gap after a clear or return-home command.

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq #(
  parameter bit          FOUR_BIT   = 1'b1,
  parameter logic [3:0]  FSET_FLAGS = 4'b1000,
  parameter int unsigned T_POWERUP  = 8_000_000,
  parameter int unsigned T_SETUP    = 20,
  parameter int unsigned T_EHIGH    = 100,
  parameter int unsigned T_ELOW     = 100,
  parameter int unsigned T_CMD      = 11_000,
  parameter int unsigned T_LONG     = 440_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       lcd_e,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic [7:0] lcd_d
);

  function automatic int unsigned mx(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned TMAX = mx(mx(mx(T_POWERUP, T_LONG), mx(T_CMD, T_SETUP)), mx(T_EHIGH, T_ELOW));
  localparam int          CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] C_PWR  = CW'(T_POWERUP - 1);
  localparam logic [CW-1:0] C_SU   = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] C_EH   = CW'(T_EHIGH - 1);
  localparam logic [CW-1:0] C_EL   = CW'(T_ELOW - 1);
  localparam logic [CW-1:0] C_CMD  = CW'(T_CMD - 1);
  localparam logic [CW-1:0] C_LONG = CW'(T_LONG - 1);
  localparam logic [2:0]    N_INIT = FOUR_BIT ? 3'd5 : 3'd4;

  typedef enum logic [2:0] {S_PWR, S_SETUP, S_EHI, S_ELO, S_WAIT, S_IDLE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [7:0]    byte_q;
  logic          rs_q, single_q, nib_lo, long_q;
  logic [2:0]    step;

  // {single strobe, byte} for each start-up item
  function automatic logic [8:0] init_item(logic [2:0] idx);
    if (idx < 3'd3)      return {1'b1, 8'h30};
    else if (idx == 3'd3) return FOUR_BIT ? {1'b1, 8'h20} : {1'b0, 4'b0011, FSET_FLAGS};
    else                  return {1'b0, 4'b0010, FSET_FLAGS};
  endfunction

  wire       cnt_done = (cnt == '0);
  wire [3:0] nib      = nib_lo ? byte_q[3:0] : byte_q[7:4];

  assign req_ready = (state == S_IDLE);
  assign lcd_e     = (state == S_EHI);
  assign lcd_rs    = rs_q;
  assign lcd_rw    = 1'b0;
  assign lcd_d     = FOUR_BIT ? {nib, 4'b0000} : byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_PWR;
      cnt      <= C_PWR;
      byte_q   <= '0;
      rs_q     <= 1'b0;
      single_q <= 1'b0;
      nib_lo   <= 1'b0;
      long_q   <= 1'b0;
      step     <= '0;
    end else begin
      case (state)
        S_PWR, S_WAIT: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (step != N_INIT) begin
            {single_q, byte_q} <= init_item(step);
            rs_q   <= 1'b0;
            nib_lo <= 1'b0;
            long_q <= 1'b1;
            cnt    <= C_SU;
            state  <= S_SETUP;
          end else state <= S_IDLE;
        end
        S_SETUP: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin cnt <= C_EH; state <= S_EHI; end
        end
        S_EHI: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin cnt <= C_EL; state <= S_ELO; end
        end
        S_ELO: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (FOUR_BIT && !single_q && !nib_lo) begin
            nib_lo <= 1'b1;
            cnt    <= C_SU;
            state  <= S_SETUP;
          end else begin
            cnt   <= long_q ? C_LONG : C_CMD;
            state <= S_WAIT;
            if (step != N_INIT) step <= step + 1'b1;
          end
        end
        S_IDLE: begin
          if (req_valid) begin
            byte_q   <= req_byte;
            rs_q     <= req_is_data;
            single_q <= 1'b0;
            nib_lo   <= 1'b0;
            long_q   <= !req_is_data && (req_byte[7:2] == 6'd0) && (req_byte[1:0] != 2'd0);
            cnt      <= C_SU;
            state    <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rw_low_R10: assert property (@(posedge clk) disable iff (!rst_n) lcd_rw == 1'b0);
  assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_d) && $stable(lcd_rs)));
  assert_closed_in_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step != N_INIT) |-> !req_ready);
  assert_closed_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lcd_e);
  assert_pair_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !nib_lo || !FOUR_BIT || single_q || (state == S_IDLE && step == N_INIT));
  assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> $stable(lcd_d) && $stable(lcd_rs));

endmodule

// File: tb/lcd_bus_seq_test.sv
`timescale 1ns/1ps
module lcd_mon #(
  parameter bit         FOUR  = 1'b1,
  parameter logic [3:0] FLAGS = 4'b1000,
  parameter int PWR = 50, SU = 2, EH = 3, CMD = 10, LONG = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       e,
  input logic       rs,
  input logic       rw,
  input logic       ready,
  input logic [7:0] d
);
  int checks = 0, fails = 0, n_bytes = 0;
  logic [9:0] q[$];
  bit e_q, seen, in_pair, rs_r, rs_first;
  int since, hi_cnt, lo_cnt, need, init_left, init_total;
  logic [7:0] d_r;
  logic [3:0] hi_nib;
  logic [9:0] it;
  string tag;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s in %m: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_long(logic [9:0] x);
    return !x[8] && (x[7:2] == 6'd0) && (x[1:0] != 2'd0);
  endfunction

  task automatic add_exp(bit r, logic [7:0] b);
    q.push_back({1'b0, r, b});
  endtask

  task automatic retire();
    q.pop_front();
    if (init_left > 0) begin init_left--; need = LONG; end
    else begin n_bytes++; need = is_long(it) ? CMD + (LONG - CMD) : CMD; end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      repeat (3) q.push_back({1'b1, 1'b0, 8'h30});
      if (FOUR) begin
        q.push_back({1'b1, 1'b0, 8'h20});
        q.push_back({1'b0, 1'b0, 4'b0010, FLAGS});
      end else q.push_back({1'b0, 1'b0, 4'b0011, FLAGS});
      init_left = q.size(); init_total = q.size();
      e_q = 0; seen = 0; in_pair = 0; since = 0; lo_cnt = 0; hi_cnt = 0; need = 0;
    end else begin
      if (ready) chk(init_left == 0 && !in_pair && !e && lo_cnt >= need, "R4", ready, 0);
      case ({e_q, e})
        2'b01: begin
          if (!seen) chk(since >= PWR, "R1", since, PWR);
          else if (!in_pair) chk(lo_cnt >= need, "R9", lo_cnt, need);
          chk(lo_cnt >= SU, "R7", lo_cnt, SU);
          seen = 1; rs_r = rs; d_r = d; hi_cnt = 1;
        end
        2'b11: begin
          hi_cnt++;
          if (rs !== rs_r || d !== d_r) chk(0, "R7", {rs, d}, {rs_r, d_r});
        end
        2'b10: begin
          chk(hi_cnt == EH, "R8", hi_cnt, EH);
          chk(rw == 1'b0, "R10", rw, 0);
          lo_cnt = 1;
          if (q.size() == 0) chk(0, "R11", {rs_r, d_r}, 0);
          else begin
            it = q[0];
            if (init_left > 0) tag = (init_total - init_left < 3) ? "R2" : "R3";
            else tag = FOUR ? "R6" : "R5";
            if (FOUR && !it[9]) begin
              if (!in_pair) begin
                in_pair = 1; hi_nib = d_r[7:4]; rs_first = rs_r;
                chk(d_r[3:0] == 4'd0, "R6", d_r, {d_r[7:4], 4'd0});
              end else begin
                in_pair = 0;
                chk(rs_r == rs_first && rs_r == it[8], tag, rs_r, it[8]);
                chk({hi_nib, d_r[7:4]} == it[7:0], tag, {hi_nib, d_r[7:4]}, it[7:0]);
                retire();
              end
            end else if (it[9]) begin
              chk(d_r[7:4] == it[7:4] && !rs_r, tag, {rs_r, d_r[7:4]}, {1'b0, it[7:4]});
              retire();
            end else begin
              chk(d_r == it[7:0] && rs_r == it[8], tag, {rs_r, d_r}, it[8:0]);
              retire();
            end
          end
        end
        default: lo_cnt++;
      endcase
      e_q = e;
      since++;
    end
  end
endmodule

module lcd_bus_seq_test;
  localparam int PWR = 50, SU = 2, EH = 3, EL = 2, CMD = 10, LONG = 40;
  localparam logic [3:0] FLAGS = 4'b1000;

  logic clk = 0, rst_n = 0;
  logic v4 = 0, r4 = 0, v8 = 0, r8 = 0;
  logic [7:0] b4 = 0, b8 = 0;
  logic rdy4, e4, rs4, rw4, rdy8, e8, rs8, rw8;
  logic [7:0] d4, d8;
  int checks = 0, fails = 0, sent4 = 0, sent8 = 0;

  always #2.5 clk = ~clk;

  lcd_bus_seq #(.FOUR_BIT(1'b1), .FSET_FLAGS(FLAGS), .T_POWERUP(PWR), .T_SETUP(SU),
    .T_EHIGH(EH), .T_ELOW(EL), .T_CMD(CMD), .T_LONG(LONG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(v4), .req_ready(rdy4), .req_is_data(r4),
    .req_byte(b4), .lcd_e(e4), .lcd_rs(rs4), .lcd_rw(rw4), .lcd_d(d4));

  lcd_bus_seq #(.FOUR_BIT(1'b0), .FSET_FLAGS(FLAGS), .T_POWERUP(PWR), .T_SETUP(SU),
    .T_EHIGH(EH), .T_ELOW(EL), .T_CMD(CMD), .T_LONG(LONG)) uut_w8 (
    .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_ready(rdy8), .req_is_data(r8),
    .req_byte(b8), .lcd_e(e8), .lcd_rs(rs8), .lcd_rw(rw8), .lcd_d(d8));

  lcd_mon #(.FOUR(1'b1), .FLAGS(FLAGS), .PWR(PWR), .SU(SU), .EH(EH), .CMD(CMD), .LONG(LONG)) mon4 (
    .clk(clk), .rst_n(rst_n), .e(e4), .rs(rs4), .rw(rw4), .ready(rdy4), .d(d4));
  lcd_mon #(.FOUR(1'b0), .FLAGS(FLAGS), .PWR(PWR), .SU(SU), .EH(EH), .CMD(CMD), .LONG(LONG)) mon8 (
    .clk(clk), .rst_n(rst_n), .e(e8), .rs(rs8), .rw(rw8), .ready(rdy8), .d(d8));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon4.checks + mon8.checks, fails + mon4.fails + mon8.fails);
    $finish;
  endtask

  task automatic send(bit w8, bit r, logic [7:0] b);
    @(negedge clk);
    if (w8) begin
      v8 = 1; r8 = r; b8 = b;
      while (!rdy8) @(negedge clk);
      mon8.add_exp(r, b); sent8++;
      @(negedge clk); v8 = 0;
    end else begin
      v4 = 1; r4 = r; b4 = b;
      while (!rdy4) @(negedge clk);
      mon4.add_exp(r, b); sent4++;
      @(negedge clk); v4 = 0;
    end
  endtask

  // R11: a request offered during start-up and withdrawn must never reach the bus
  task automatic offer_and_withdraw(bit w8);
    @(negedge clk);
    if (w8) begin v8 = 1; r8 = 1; b8 = 8'hEE; end
    else begin v4 = 1; r4 = 1; b4 = 8'hEE; end
    repeat (5) @(negedge clk);
    v8 = w8 ? 1'b0 : v8;
    v4 = w8 ? v4 : 1'b0;
  endtask

  task automatic run(bit w8);
    logic [7:0] b;
    bit r;
    offer_and_withdraw(w8);
    send(w8, 0, 8'h01);
    send(w8, 1, 8'h00);
    send(w8, 0, 8'h02);
    send(w8, 1, 8'hFF);
    send(w8, 0, 8'h03);
    send(w8, 1, 8'hA5);
    send(w8, 0, 8'h04);
    send(w8, 0, 8'h80);
    for (int i = 0; i < 40; i++) begin
      r = 1'($urandom % 2);
      b = 8'($urandom);
      if (!r && ($urandom % 4 == 0)) b = 8'(1 + $urandom % 3);
      send(w8, r, b);
      repeat ($urandom % 4) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rdy4 && !e4, "R1", {rdy4, e4}, 0);
    chk(!rdy8 && !e8, "R1", {rdy8, e8}, 0);
    fork
      run(1'b0);
      run(1'b1);
    join
    while (!(rdy4 && rdy8)) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(mon4.q.size() == 0, "R6", mon4.q.size(), 0);
    chk(mon8.q.size() == 0, "R5", mon8.q.size(), 0);
    chk(mon4.n_bytes == sent4, "R11", mon4.n_bytes, sent4);
    chk(mon8.n_bytes == sent8, "R11", mon8.n_bytes, sent8);
    chk(rw4 == 0 && rw8 == 0, "R10", {rw4, rw8}, 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end
endmodule